// File: doc/BRIEF.md
# Two-Thread Core Idle-State Controller

This block keeps one idle-state machine for each hardware thread of a core and reports a single core-level idle state. Each thread machine takes decoded entry commands (halt, monitor-wait with a target depth, and port-I/O idle requests) and wake events (interrupt and write to the monitored line). Snoops may also arrive while a thread sleeps. Each thread enters and leaves its idle state on its own, without regard to the other thread.

The core state is the shallowest state held by any enabled thread, computed as a numeric minimum over a five-level ordered encoding. It is registered. A one-cycle strobe marks each change so that a power controller outside the core can follow it. The thread count is a parameter, with a default of two.

Top module: `cidle_core`

## Requirements
- R1: States are encoded in 3 bits as C0=0, C1=1, C1E=2, C3=3, C6=4, so a larger value means a deeper state. After reset every thread is in C0, `core_state` is C0 and `core_chg` is 0.
- R2: Command kinds per thread are 0 none, 1 halt, 2 monitor-wait, 3 port-I/O. From C0, a halt (target ignored) or a monitor-wait with target 1 moves the thread to C1 on the next clock edge. A monitor-wait with target 2 moves it to C1E.
- R3: From C0, a monitor-wait with target 3 or 4 moves the thread to C3 or C6, and so does a port-I/O command with target 3 or 4. A monitor-wait with target 0 or above 4, and a port-I/O command with any other target, leave the thread in C0.
- R4: An entry command given while the thread is not in C0 has no effect.
- R5: An interrupt returns the thread to C0 on the next edge from any state. It takes precedence over an entry command in the same cycle.
- R6: A monitored-line write returns a thread to C0 only if its current idle state was entered through monitor-wait. Otherwise it has no effect.
- R7: A snoop never changes a thread's state, including in C1 and C1E.
- R8: `core_state` takes, one edge after the thread states, the minimum state over enabled threads. With no thread enabled it is C6. Disabled threads keep running their own state machines.
- R9: `core_chg` is high for exactly the cycles in which `core_state` has just taken a value different from its previous one.
- R10: A command, interrupt or monitored-line write for one thread leaves the other thread's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_kind | input | 2*NUM_THREADS | Per-thread command kind; thread t uses bits [2t+1:2t] |
| req_tgt | input | 3*NUM_THREADS | Per-thread target depth; thread t uses bits [3t+2:3t] |
| irq | input | NUM_THREADS | Per-thread interrupt |
| mon_wr | input | NUM_THREADS | Per-thread monitored-line write |
| snoop | input | NUM_THREADS | Per-thread snoop arrival |
| thr_en | input | NUM_THREADS | Thread takes part in resolution |
| thr_state | output | 3*NUM_THREADS | Per-thread current state |
| core_state | output | 3 | Registered resolved core state |
| core_chg | output | 1 | One-cycle strobe when the core state changes |

## Verification
Threads are driven with each entry kind and target, including the invalid targets. This separates a correct entry decode from one that accepts any target. Monitored-line writes are applied to threads that entered through monitor-wait and to threads that entered through halt or port-I/O, which exposes a missing entry-method flag. Interrupts are raised together with entry commands, and commands are issued while a thread already sleeps, to confirm the precedence and the C0-only acceptance. The enable pattern is stepped through both, one and no threads, with the threads at different depths. This shows whether the minimum is taken over enabled threads only and whether the strobe follows each change of the core state.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
   localparam int unsigned ST_W   = 3;
   localparam int unsigned KIND_W = 2;

   typedef enum logic [ST_W-1:0] {
      CST_C0  = 3'd0,
      CST_C1  = 3'd1,
      CST_C1E = 3'd2,
      CST_C3  = 3'd3,
      CST_C6  = 3'd4
   } cst_e;

   typedef enum logic [KIND_W-1:0] {
      RK_NONE  = 2'd0,
      RK_HALT  = 2'd1,
      RK_MWAIT = 2'd2,
      RK_PORT  = 2'd3
   } req_kind_e;

   function automatic logic deep_tgt(input logic [ST_W-1:0] t);
      return (t == CST_C3) || (t == CST_C6);
   endfunction

   function automatic logic mwait_tgt_ok(input logic [ST_W-1:0] t);
      return (t >= CST_C1) && (t <= CST_C6);
   endfunction
endpackage

// File: rtl/cidle_thread.sv
module cidle_thread
   import cidle_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [KIND_W-1:0]      kind,
   input  logic [ST_W-1:0]        tgt,
   input  logic                   irq,
   input  logic                   mon_wr,
   input  logic                   snoop,
   output logic [ST_W-1:0]        state_o
);
   cst_e st_q, st_d;
   logic via_mw_q, via_mw_d;

   always_comb begin
      st_d     = st_q;
      via_mw_d = via_mw_q;
      if (irq) begin
         st_d     = CST_C0;
         via_mw_d = 1'b0;
      end else if (st_q == CST_C0) begin
         unique case (req_kind_e'(kind))
            RK_HALT: begin
               st_d     = CST_C1;
               via_mw_d = 1'b0;
            end
            RK_MWAIT: begin
               if (mwait_tgt_ok(tgt)) begin
                  st_d     = cst_e'(tgt);
                  via_mw_d = 1'b1;
               end
            end
            RK_PORT: begin
               if (deep_tgt(tgt)) begin
                  st_d     = cst_e'(tgt);
                  via_mw_d = 1'b0;
               end
            end
            default: ;
         endcase
      end else if (mon_wr && via_mw_q) begin
         st_d     = CST_C0;
         via_mw_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= CST_C0;
         via_mw_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         via_mw_q <= via_mw_d;
      end
   end

   assign state_o = st_q;

   AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> st_q == CST_C0); // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != CST_C0 && !irq && !mon_wr) |=> st_q == $past(st_q)); // R4
   AST_SNOOP_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop && (st_q == CST_C1 || st_q == CST_C1E) && !irq && !mon_wr)
      |=> st_q == $past(st_q)); // R7
   AST_HALT_C1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CST_C0 && !irq && kind == RK_HALT) |=> st_q == CST_C1); // R2
   AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != CST_C0 && !irq && mon_wr && !via_mw_q) |=> st_q == $past(st_q)); // R6
endmodule

// File: rtl/cidle_resolve.sv
module cidle_resolve
   import cidle_pkg::*;
#(
   parameter int unsigned NUM_THREADS = 2
) (
   input  logic [NUM_THREADS*ST_W-1:0] thr_state,
   input  logic [NUM_THREADS-1:0]      thr_en,
   output logic [ST_W-1:0]             shallowest
);
   logic [ST_W-1:0] cand [NUM_THREADS];

   for (genvar g = 0; g < NUM_THREADS; g++) begin : g_cand
      assign cand[g] = thr_en[g] ? thr_state[g*ST_W +: ST_W] : CST_C6;
   end

   always_comb begin
      shallowest = CST_C6;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (cand[i] < shallowest) shallowest = cand[i];
      end
   end
endmodule

// File: rtl/cidle_core.sv
module cidle_core
   import cidle_pkg::*;
#(
   parameter int unsigned NUM_THREADS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_THREADS*KIND_W-1:0] req_kind,
   input  logic [NUM_THREADS*ST_W-1:0]   req_tgt,
   input  logic [NUM_THREADS-1:0]        irq,
   input  logic [NUM_THREADS-1:0]        mon_wr,
   input  logic [NUM_THREADS-1:0]        snoop,
   input  logic [NUM_THREADS-1:0]        thr_en,
   output logic [NUM_THREADS*ST_W-1:0]   thr_state,
   output logic [ST_W-1:0]               core_state,
   output logic                          core_chg
);
   if (NUM_THREADS < 1 || NUM_THREADS > 64) begin : g_bad_param
      $error("cidle_core: NUM_THREADS must lie in 1..64");
   end

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      cidle_thread u_thr (
         .clk     (clk),
         .rst_n   (rst_n),
         .kind    (req_kind[t*KIND_W +: KIND_W]),
         .tgt     (req_tgt[t*ST_W +: ST_W]),
         .irq     (irq[t]),
         .mon_wr  (mon_wr[t]),
         .snoop   (snoop[t]),
         .state_o (thr_state[t*ST_W +: ST_W])
      );
   end

   logic [ST_W-1:0] resolved;

   cidle_resolve #(.NUM_THREADS(NUM_THREADS)) u_res (
      .thr_state  (thr_state),
      .thr_en     (thr_en),
      .shallowest (resolved)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_state <= CST_C0;
         core_chg   <= 1'b0;
      end else begin
         core_state <= resolved;
         core_chg   <= (resolved != core_state);
      end
   end

   AST_CHG_MEANS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      core_chg |-> core_state != $past(core_state)); // R9
   AST_NO_CHG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !core_chg |-> core_state == $past(core_state)); // R9
   AST_CORE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      core_state <= CST_C6); // R1

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
      AST_NOT_DEEPER: assert property (@(posedge clk) disable iff (!rst_n)
         $past(thr_en[t]) |-> core_state <= $past(thr_state[t*ST_W +: ST_W])); // R8
   end
endmodule

// File: tb/test_cidle_core.sv
module test_cidle_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req_kind = '0;
   logic [5:0] req_tgt = '0;
   logic [1:0] irq = '0, mon_wr = '0, snoop = '0, thr_en = 2'b11;
   logic [5:0] thr_state;
   logic [2:0] core_state;
   logic       core_chg;

   int checks = 0, errors = 0;
   bit done = 0;

   int  mst [2];
   bit  mmw [2];
   int  mcore;
   bit  mchg;

   always #5 clk = ~clk;

   cidle_core #(.NUM_THREADS(2)) i_cidle_core (
      .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_tgt(req_tgt),
      .irq(irq), .mon_wr(mon_wr), .snoop(snoop), .thr_en(thr_en),
      .thr_state(thr_state), .core_state(core_state), .core_chg(core_chg));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "thread0", int'(thr_state[2:0]), mst[0]);
      chk(tag, "thread1", int'(thr_state[5:3]), mst[1]);
      chk(tag, "core_state", int'(core_state), mcore);
      chk(tag, "core_chg", int'(core_chg), int'(mchg));
   endtask

   task automatic step(input int k0, input int t0, input int k1, input int t1,
                       input bit [1:0] i, input bit [1:0] m, input bit [1:0] s,
                       input bit [1:0] e, input string tag);
      int nc;
      int k [2];
      int t [2];
      req_kind = {2'(k1), 2'(k0)};
      req_tgt  = {3'(t1), 3'(t0)};
      irq = i; mon_wr = m; snoop = s; thr_en = e;
      k[0] = k0; k[1] = k1; t[0] = t0; t[1] = t1;
      @(posedge clk);
      nc = 4;
      for (int n = 0; n < 2; n++) if (e[n] && mst[n] < nc) nc = mst[n];
      mchg  = (nc != mcore);
      mcore = nc;
      for (int n = 0; n < 2; n++) begin
         if (i[n]) begin
            mst[n] = 0; mmw[n] = 0;
         end else if (mst[n] == 0) begin
            if (k[n] == 1) begin mst[n] = 1; mmw[n] = 0; end
            else if (k[n] == 2 && t[n] >= 1 && t[n] <= 4) begin mst[n] = t[n]; mmw[n] = 1; end
            else if (k[n] == 3 && (t[n] == 3 || t[n] == 4)) begin mst[n] = t[n]; mmw[n] = 0; end
         end else if (m[n] && mmw[n]) begin
            mst[n] = 0; mmw[n] = 0;
         end
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input bit [1:0] e, input string tag);
      step(0, 0, 0, 0, 2'b00, 2'b00, 2'b00, e, tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      mst[0] = 0; mst[1] = 0; mmw[0] = 0; mmw[1] = 0; mcore = 0; mchg = 0;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      idle(2'b11, "R1");
      // halt on thread 0, monitor-wait C1E on thread 1
      step(1, 7, 0, 0, 2'b00, 2'b00, 2'b00, 2'b11, "R2 halt");
      step(0, 0, 2, 2, 2'b00, 2'b00, 2'b00, 2'b11, "R2 mwait C1E");
      idle(2'b11, "R8 core C1");
      idle(2'b11, "R9 strobe");
      // snoops while in C1/C1E
      step(0, 0, 0, 0, 2'b00, 2'b00, 2'b11, 2'b11, "R7 snoop");
      // requests while idle ignored
      step(3, 4, 2, 4, 2'b00, 2'b00, 2'b00, 2'b11, "R4 ignore");
      // monitor write: thread 0 entered via halt, thread 1 via mwait
      step(0, 0, 0, 0, 2'b00, 2'b11, 2'b00, 2'b11, "R6 mon write");
      idle(2'b11, "R10");
      // interrupt thread 0 with simultaneous request
      step(2, 4, 0, 0, 2'b01, 2'b00, 2'b00, 2'b11, "R5 irq wins");
      idle(2'b11, "R5");
      // deep entries
      step(3, 3, 2, 4, 2'b00, 2'b00, 2'b00, 2'b11, "R3 deep");
      idle(2'b11, "R8 core C3");
      step(0, 0, 0, 0, 2'b00, 2'b01, 2'b11, 2'b11, "R6 port no wake");
      idle(2'b10, "R8 only t1");
      idle(2'b00, "R8 none enabled");
      idle(2'b01, "R8 only t0");
      step(0, 0, 0, 0, 2'b00, 2'b10, 2'b00, 2'b11, "R6 mwait C6 wake");
      idle(2'b11, "R9");
      step(0, 0, 0, 0, 2'b01, 2'b00, 2'b00, 2'b11, "R5 from C3");
      idle(2'b11, "R5");
      // invalid targets
      step(2, 0, 2, 5, 2'b00, 2'b00, 2'b00, 2'b11, "R3 bad mwait");
      step(3, 1, 3, 2, 2'b00, 2'b00, 2'b00, 2'b11, "R3 bad port");
      step(2, 1, 3, 4, 2'b00, 2'b00, 2'b00, 2'b11, "R2 mwait C1");
      idle(2'b11, "R8");
      step(0, 0, 0, 0, 2'b00, 2'b01, 2'b00, 2'b10, "R6 disabled t0");
      idle(2'b11, "R9");
      step(0, 0, 0, 0, 2'b11, 2'b00, 2'b00, 2'b11, "R5 both");
      idle(2'b11, "R9 back C0");
      idle(2'b11, "R9 steady");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule